// File: doc/BRIEF.md
# Serial EEPROM Command and Page-Write Controller

This block is the command layer of a small serial EEPROM. A two-wire front end below it turns bus activity into single-cycle events: START seen, STOP seen, a received byte, and a request for the next byte to transmit. The block decodes the control byte that opens every transaction. It loads the word pointer from the bank-select bits and the word-address byte. It gathers write data into a page buffer and, after STOP, copies that buffer into an internal byte array while a busy window runs. In the other direction it hands out array bytes for reads.

A write transaction is control byte, word address, then any number of data bytes. Data bytes land in the page buffer at the pointer's low bits, and the page bits of the pointer never move. When more bytes arrive than the page holds, the oldest are overwritten. On STOP only the entries written in this transaction reach the array, and only when write protect is low. For the whole self-timed window the block answers nothing at all. A read transaction streams bytes from the pointer, and the pointer advances across the whole array.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: After reset, `busy_o`, `ack_o` and `rd_vld_o` are low.
- R2: A control byte is acknowledged (`ack_o` high for one cycle, the cycle after `byte_vld_i`) only when bits 7:4 equal 4'b1010. Otherwise it and every later byte up to the next START get no acknowledge.
- R3: In a control byte, bit 0 selects read (1) or write (0). In a write, the next byte is loaded into the low 8 bits of the pointer. Every byte of a write is acknowledged.
- R4: Each data byte is stored in the page buffer at the pointer's low 4 bits. Only those 4 bits then increment, wrapping within the 16-byte page, and the upper pointer bits stay fixed.
- R5: When more than 16 data bytes arrive before STOP, the later bytes overwrite the earlier ones in arrival order, so the array receives the last 16.
- R6: A STOP that ends a write with at least one data byte raises `busy_o` in the next cycle for exactly WR_CYCLES cycles. Only the bytes received in that write change the array; other bytes of the page keep their values.
- R7: While `busy_o` is high, no byte is acknowledged, including a control byte, and START, STOP and read requests have no effect.
- R8: With `wp_i` high at STOP, bytes are still acknowledged, but no write cycle starts and the array is unchanged.
- R9: In a read, each `rd_req_i` pulse returns the byte at the pointer on `rd_data_o` with `rd_vld_o` high in the next cycle, then increments the full pointer, which wraps from the last array byte to 0.
- R10: A STOP right after the word address loads the pointer but starts no write cycle.
- R11: A START that arrives during a write, before STOP, discards the buffered data, so nothing is committed.
- R12: The bank-select bits are the pointer's upper bits: bits 2:1 with four banks, bit 1 alone with two. Bit 3 is always ignored, and bit 2 is ignored with two banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START detected |
| stop_i | input | 1 | One-cycle pulse: STOP detected |
| byte_vld_i | input | 1 | One-cycle pulse: a byte from the master is complete |
| byte_i | input | 8 | Received byte, valid with `byte_vld_i` |
| rd_req_i | input | 1 | One-cycle pulse: front end needs the next byte to send |
| wp_i | input | 1 | Write protect; high blocks any commit to the array |
| ack_o | output | 1 | One-cycle pulse: drive acknowledge for the last byte |
| rd_vld_o | output | 1 | One-cycle pulse: `rd_data_o` holds a read byte |
| rd_data_o | output | 8 | Byte to transmit |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
A wrong internal state shows up quickly at the ports. A state machine left in the wrong phase changes the acknowledge pulse one cycle after the next byte. A busy counter that is off makes `busy_o` fall a cycle early or late. A pointer or page-buffer fault stays hidden until the next read, where the wrong byte comes out on `rd_data_o`. For that reason every write scenario is followed by a read-back of the whole affected region, including bytes that must not have changed. The reference model in the bench is compared with `ack_o`, `busy_o`, `rd_vld_o` and `rd_data_o` on every clock.

// File: rtl/eep_pkg.sv
package eep_pkg;

   localparam logic [3:0] CTRL_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_WADDR,
      ST_WDATA,
      ST_READ,
      ST_SKIP
   } cmd_state_e;

endpackage

// File: rtl/eep_cmd_fsm.sv
module eep_cmd_fsm
   import eep_pkg::*;
#(
   parameter int AW        = 9,
   parameter int BANK_BITS = 1,
   parameter int PAGE_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 stop_i,
   input  logic                 byte_vld_i,
   input  logic [7:0]           byte_i,
   input  logic                 rd_req_i,
   input  logic                 busy_i,
   input  logic                 wp_i,
   output logic                 ack_o,
   output logic [AW-1:0]        ptr_o,
   output logic                 wr_en_o,
   output logic [PAGE_BITS-1:0] wr_idx_o,
   output logic                 clr_o,
   output logic                 commit_o,
   output logic                 rd_en_o
);

   cmd_state_e          state_q;
   logic [AW-1:0]       ptr_q;
   logic                have_data_q;
   logic                ack_q;
   logic [BANK_BITS-1:0] bank_sel;
   logic                quiet;

   // bank bits taken from the control byte; the variant follows the bank count
   generate
      if (BANK_BITS == 2) begin : g_four_banks
         logic unused_b3;
         assign bank_sel  = byte_i[2:1];
         assign unused_b3 = byte_i[3];
      end else begin : g_two_banks
         logic unused_b32;
         assign bank_sel   = byte_i[1];
         assign unused_b32 = byte_i[3] ^ byte_i[2];
      end
   endgenerate

   assign quiet    = !busy_i && !start_i && !stop_i;
   assign wr_en_o  = quiet && byte_vld_i && (state_q == ST_WDATA);
   assign wr_idx_o = ptr_q[PAGE_BITS-1:0];
   assign rd_en_o  = quiet && !byte_vld_i && rd_req_i && (state_q == ST_READ);
   assign clr_o    = !busy_i && start_i;
   assign commit_o = !busy_i && !start_i && stop_i && (state_q == ST_WDATA)
                     && have_data_q && !wp_i;
   assign ack_o    = ack_q;
   assign ptr_o    = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ptr_q       <= '0;
         have_data_q <= 1'b0;
         ack_q       <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         if (busy_i) begin
            state_q <= ST_IDLE;
         end else if (start_i) begin
            state_q     <= ST_CTRL;
            have_data_q <= 1'b0;
         end else if (stop_i) begin
            state_q <= ST_IDLE;
         end else if (byte_vld_i) begin
            unique case (state_q)
               ST_CTRL: begin
                  if (byte_i[7:4] == CTRL_CODE) begin
                     ack_q          <= 1'b1;
                     ptr_q[AW-1:8]  <= bank_sel;
                     state_q        <= byte_i[0] ? ST_READ : ST_WADDR;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
               ST_WADDR: begin
                  ack_q      <= 1'b1;
                  ptr_q[7:0] <= byte_i;
                  state_q    <= ST_WDATA;
               end
               ST_WDATA: begin
                  ack_q                    <= 1'b1;
                  ptr_q[PAGE_BITS-1:0]     <= ptr_q[PAGE_BITS-1:0] + 1'b1;
                  have_data_q              <= 1'b1;
               end
               default: ;
            endcase
         end else if (rd_en_o) begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   // R4: a data byte never moves the page part of the pointer
   p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> (ptr_q[AW-1:PAGE_BITS] == $past(ptr_q[AW-1:PAGE_BITS])));

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int PAGE_BYTES = 16,
   parameter int PAGE_BITS  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 wr_i,
   input  logic [PAGE_BITS-1:0] wr_idx_i,
   input  logic [7:0]           wr_data_i,
   input  logic [PAGE_BITS-1:0] rd_idx_i,
   output logic [7:0]           rd_data_o,
   output logic                 rd_valid_o
);

   logic [7:0] ent_data [PAGE_BYTES];
   logic       ent_vld  [PAGE_BYTES];

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
         logic [7:0] d_q;
         logic       v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else if (clr_i) begin
               v_q <= 1'b0;
            end else if (wr_i && (wr_idx_i == PAGE_BITS'(g))) begin
               d_q <= wr_data_i;
               v_q <= 1'b1;
            end
         end
         assign ent_data[g] = d_q;
         assign ent_vld[g]  = v_q;
      end
   endgenerate

   assign rd_data_o  = ent_data[rd_idx_i];
   assign rd_valid_o = ent_vld[rd_idx_i];

   // R11: clearing and filling never coincide
   p_clr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_i && wr_i));

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
   parameter int WR_CYCLES  = 40,
   parameter int PAGE_BYTES = 16,
   parameter int PAGE_BITS  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 commit_i,
   output logic                 busy_o,
   output logic                 copy_en_o,
   output logic [PAGE_BITS-1:0] copy_idx_o
);

   localparam int CW = $clog2(WR_CYCLES + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (commit_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(WR_CYCLES - 1)) busy_q <= 1'b0;
      end
   end

   assign busy_o     = busy_q;
   assign copy_en_o  = busy_q && (cnt_q < CW'(PAGE_BYTES));
   assign copy_idx_o = cnt_q[PAGE_BITS-1:0];

   // R6: the window counter stays inside the programmed length
   p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < CW'(WR_CYCLES)));

   // R7: no new commit can be requested while a window runs
   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !commit_i);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o,
   output logic          rvld_o
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
         rvld_o  <= 1'b0;
      end else begin
         rvld_o <= re_i;
         if (re_i) rdata_o <= mem[raddr_i];
      end
   end

   // R7: reads and array writes are never in flight together
   p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && re_i));

endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl #(
   parameter int NUM_BANKS  = 2,
   parameter int PAGE_BYTES = 16,
   parameter int WR_CYCLES  = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       byte_vld_i,
   input  logic [7:0] byte_i,
   input  logic       rd_req_i,
   input  logic       wp_i,
   output logic       ack_o,
   output logic       rd_vld_o,
   output logic [7:0] rd_data_o,
   output logic       busy_o
);

   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int AW        = 8 + BANK_BITS;
   localparam int PAGE_BITS = $clog2(PAGE_BYTES);

   generate
      if (!(NUM_BANKS == 2 || NUM_BANKS == 4)) begin : g_bad_banks
         $error("eep_cmd_ctrl: NUM_BANKS must be 2 or 4");
      end
      if ((1 << PAGE_BITS) != PAGE_BYTES || PAGE_BYTES < 2 || PAGE_BYTES > 256) begin : g_bad_page
         $error("eep_cmd_ctrl: PAGE_BYTES must be a power of two from 2 to 256");
      end
      if (WR_CYCLES < PAGE_BYTES) begin : g_bad_cycles
         $error("eep_cmd_ctrl: WR_CYCLES must cover one copy step per page byte");
      end
   endgenerate

   logic [AW-1:0]        ptr;
   logic                 wr_en, clr, commit, rd_en;
   logic [PAGE_BITS-1:0] wr_idx, copy_idx;
   logic                 copy_en;
   logic [7:0]           buf_data;
   logic                 buf_valid;

   eep_cmd_fsm #(
      .AW        (AW),
      .BANK_BITS (BANK_BITS),
      .PAGE_BITS (PAGE_BITS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .rd_req_i   (rd_req_i),
      .busy_i     (busy_o),
      .wp_i       (wp_i),
      .ack_o      (ack_o),
      .ptr_o      (ptr),
      .wr_en_o    (wr_en),
      .wr_idx_o   (wr_idx),
      .clr_o      (clr),
      .commit_o   (commit),
      .rd_en_o    (rd_en)
   );

   eep_page_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .PAGE_BITS  (PAGE_BITS)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .wr_i       (wr_en),
      .wr_idx_i   (wr_idx),
      .wr_data_i  (byte_i),
      .rd_idx_i   (copy_idx),
      .rd_data_o  (buf_data),
      .rd_valid_o (buf_valid)
   );

   eep_wr_timer #(
      .WR_CYCLES  (WR_CYCLES),
      .PAGE_BYTES (PAGE_BYTES),
      .PAGE_BITS  (PAGE_BITS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .busy_o     (busy_o),
      .copy_en_o  (copy_en),
      .copy_idx_o (copy_idx)
   );

   eep_array #(
      .AW (AW)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (copy_en && buf_valid),
      .waddr_i ({ptr[AW-1:PAGE_BITS], copy_idx}),
      .wdata_i (buf_data),
      .re_i    (rd_en),
      .raddr_i (ptr),
      .rdata_o (rd_data_o),
      .rvld_o  (rd_vld_o)
   );

   // R2: an acknowledge only ever answers a byte
   p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(byte_vld_i));

   // R7: nothing is acknowledged for a byte seen during the write window
   p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !$past(busy_o));

   // R6: the write window opens only on a STOP
   p_busy_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));

   // R8: write protect at STOP keeps the window shut
   p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(wp_i));

   // R9: read data only answers a request
   p_rd_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld_o |-> $past(rd_req_i));

endmodule

// File: tb/eep_cmd_ctrl_test.sv
module eep_cmd_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 2;
   localparam int WRC        = 40;
   localparam int DEPTH      = NB * 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, rd_req_i = 1'b0, wp_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       ack_o, rd_vld_o, busy_o;
   logic [7:0] rd_data_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   eep_cmd_ctrl #(.NUM_BANKS(NB), .PAGE_BYTES(16), .WR_CYCLES(WRC)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i), .wp_i(wp_i),
      .ack_o(ack_o), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .busy_o(busy_o));

   // ---------------- behavioural reference model ----------------
   int mem [DEPTH];
   int pend_addr[$];
   int pend_data[$];
   int m_state;     // 0 idle, 1 control, 2 address, 3 data, 4 read, 5 skip
   int m_ptr;
   int busy_left;
   int e_ack, e_rvld, e_rdata;

   initial for (int i = 0; i < DEPTH; i++) mem[i] = -1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_ptr = 0; busy_left = 0;
         e_ack = 0; e_rvld = 0; e_rdata = -1;
         pend_addr.delete(); pend_data.delete();
      end else begin
         e_ack = 0; e_rvld = 0;
         if (busy_left > 0) begin
            busy_left--;
            m_state = 0;
         end else if (start_i) begin
            m_state = 1;
            pend_addr.delete(); pend_data.delete();
         end else if (stop_i) begin
            if (m_state == 3 && pend_addr.size() > 0 && !wp_i) begin
               foreach (pend_addr[k]) mem[pend_addr[k]] = pend_data[k];
               busy_left = WRC;
            end
            m_state = 0;
         end else if (byte_vld_i) begin
            case (m_state)
               1: if ((int'(byte_i) >> 4) == 10) begin
                     e_ack = 1;
                     m_ptr = (((int'(byte_i) >> 1) & (NB - 1)) * 256) + (m_ptr % 256);
                     m_state = byte_i[0] ? 4 : 2;
                  end else m_state = 5;
               2: begin e_ack = 1; m_ptr = (m_ptr / 256) * 256 + int'(byte_i); m_state = 3; end
               3: begin
                     e_ack = 1;
                     pend_addr.push_back(m_ptr); pend_data.push_back(int'(byte_i));
                     m_ptr = (m_ptr / 16) * 16 + ((m_ptr + 1) % 16);
                  end
               default: ;
            endcase
         end else if (rd_req_i && m_state == 4) begin
            e_rvld = 1; e_rdata = mem[m_ptr];
            m_ptr = (m_ptr + 1) % DEPTH;
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, "busy_o", int'(busy_o), (busy_left > 0) ? 1 : 0);
         check(cur_req, "ack_o", int'(ack_o), e_ack);
         check(cur_req, "rd_vld_o", int'(rd_vld_o), e_rvld);
         if (e_rvld == 1 && e_rdata >= 0)
            check(cur_req, "rd_data_o", int'(rd_data_o), e_rdata);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic idle(int n); repeat (n) @(negedge clk); endtask

   task automatic do_start; @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; endtask

   task automatic do_stop(int exp_busy, string req);
      @(negedge clk) stop_i = 1;
      @(negedge clk) stop_i = 0;
      check(req, "busy after STOP", int'(busy_o), exp_busy);
   endtask

   task automatic send(logic [7:0] b, int exp_ack, string req);
      @(negedge clk) begin byte_vld_i = 1; byte_i = b; end
      @(negedge clk) byte_vld_i = 0;
      check(req, "ack", int'(ack_o), exp_ack);
      idle(1);
   endtask

   task automatic rd_expect(int exp, string req);
      @(negedge clk) rd_req_i = 1;
      @(negedge clk) rd_req_i = 0;
      check(req, "rd_vld", int'(rd_vld_o), 1);
      if (exp >= 0) check(req, "rd_data", int'(rd_data_o), exp);
   endtask

   task automatic wait_ready;
      while (busy_left > 0) @(negedge clk);
      idle(2);
   endtask

   // random read set-up: control(write) + address, repeated START, control(read)
   task automatic seek(logic [7:0] ctrl_w, logic [7:0] addr, string req);
      do_start; send(ctrl_w, 1, req); send(addr, 1, req);
      do_start; send(ctrl_w | 8'h01, 1, req);
   endtask

   initial begin
      idle(3);
      check("R1", "busy reset", int'(busy_o), 0);
      check("R1", "ack reset", int'(ack_o), 0);
      check("R1", "rd_vld reset", int'(rd_vld_o), 0);
      @(negedge clk) rst_n = 1;
      idle(2);

      // R3/R4: byte write of three bytes, then read back
      cur_req = "R3";
      do_start; send(8'hA0, 1, "R3"); send(8'h10, 1, "R3");
      send(8'h11, 1, "R4"); send(8'h22, 1, "R4"); send(8'h33, 1, "R4");
      do_stop(1, "R6");
      wait_ready;
      cur_req = "R4";
      seek(8'hA0, 8'h10, "R4");
      rd_expect(8'h11, "R4"); rd_expect(8'h22, "R4"); rd_expect(8'h33, "R4");
      do_stop(0, "R4"); idle(2);

      // R10: STOP after the word address only loads the pointer
      cur_req = "R10";
      do_start; send(8'hA0, 1, "R10"); send(8'h12, 1, "R10");
      do_stop(0, "R10");
      do_start; send(8'hA1, 1, "R10");
      rd_expect(8'h33, "R10");
      do_stop(0, "R10"); idle(2);

      // R6: partial page update keeps neighbours; window length exact
      cur_req = "R6";
      do_start; send(8'hA0, 1, "R6"); send(8'h50, 1, "R6");
      for (int i = 1; i <= 4; i++) send(8'(i), 1, "R6");
      do_stop(1, "R6");
      wait_ready;
      do_start; send(8'hA0, 1, "R6"); send(8'h51, 1, "R6"); send(8'hAA, 1, "R6");
      do_stop(1, "R6");
      begin
         int high = 1;
         // R7: everything is ignored while the window runs
         cur_req = "R7";
         do_start; high += 2;
         send(8'hA1, 0, "R7"); high += 3;
         while (busy_o) begin @(negedge clk); high++; end
         check("R6", "busy window length", high - 1, WRC);
      end
      idle(2);
      cur_req = "R6";
      seek(8'hA0, 8'h50, "R6");
      rd_expect(8'h01, "R6"); rd_expect(8'hAA, "R6");
      rd_expect(8'h03, "R6"); rd_expect(8'h04, "R6");
      do_stop(0, "R6"); idle(2);

      // R8: write protect suppresses the commit
      cur_req = "R8";
      wp_i = 1;
      do_start; send(8'hA0, 1, "R8"); send(8'h10, 1, "R8"); send(8'hEE, 1, "R8");
      do_stop(0, "R8");
      idle(2); wp_i = 0;
      seek(8'hA0, 8'h10, "R8");
      rd_expect(8'h11, "R8");
      do_stop(0, "R8"); idle(2);

      // R2: wrong device code is not acknowledged, nor what follows
      cur_req = "R2";
      do_start; send(8'hB0, 0, "R2"); send(8'h10, 0, "R2"); send(8'h55, 0, "R2");
      do_stop(0, "R2");
      do_start; send(8'h20, 0, "R2");
      do_stop(0, "R2"); idle(2);

      // R5: 20 bytes into one page, last 16 survive
      cur_req = "R5";
      do_start; send(8'hA2, 1, "R5"); send(8'h2C, 1, "R5");
      for (int k = 0; k < 20; k++) send(8'(8'h60 + k), 1, "R5");
      do_stop(1, "R5");
      wait_ready;
      seek(8'hA2, 8'h20, "R5");
      for (int i = 0; i < 16; i++) rd_expect(8'h64 + i, "R5");
      do_stop(0, "R5"); idle(2);

      // R9: read crosses the top of the array back to address 0
      cur_req = "R9";
      do_start; send(8'hA2, 1, "R9"); send(8'hFF, 1, "R9"); send(8'h5A, 1, "R9");
      do_stop(1, "R9"); wait_ready;
      do_start; send(8'hA0, 1, "R9"); send(8'h00, 1, "R9"); send(8'hA5, 1, "R9");
      do_stop(1, "R9"); wait_ready;
      seek(8'hA2, 8'hFF, "R9");
      rd_expect(8'h5A, "R9"); rd_expect(8'hA5, "R9");
      do_stop(0, "R9"); idle(2);

      // R11: repeated START inside a write drops the page
      cur_req = "R11";
      do_start; send(8'hA0, 1, "R11"); send(8'h10, 1, "R11"); send(8'h99, 1, "R11");
      do_start;
      do_stop(0, "R11");
      seek(8'hA0, 8'h10, "R11");
      rd_expect(8'h11, "R11");
      do_stop(0, "R11"); idle(2);

      // R12: bit 3 and bit 2 ignored with two banks, bit 1 picks the bank
      cur_req = "R12";
      do_start; send(8'hAE, 1, "R12"); send(8'h40, 1, "R12"); send(8'hC3, 1, "R12");
      do_stop(1, "R12"); wait_ready;
      seek(8'hA2, 8'h40, "R12");
      rd_expect(8'hC3, "R12");
      do_stop(0, "R12");
      do_start; send(8'hAA, 1, "R12"); send(8'h40, 1, "R12");
      do_start; send(8'hAB, 1, "R12");
      rd_expect(8'hC3, "R12");
      do_stop(0, "R12"); idle(3);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule